// File: doc/BRIEF.md
# Three-Term Power-of-Two FIR Filter

This block is a direct-form FIR filter that uses no multipliers. Each coefficient is fixed at build time as the sum of three signed powers of two. A tap product is therefore formed from three shifted copies of the delayed sample, and each copy is either added or subtracted. The tap count and the exponent and sign of every term are parameters. Exponents may be negative, so a coefficient can carry a fractional part.

Samples arrive as signed two's-complement words, each qualified by a valid strobe. Every accepted sample moves the delay line one place and produces exactly one output after a fixed pipeline latency. The output is kept at full precision: it has `-E_MIN` fraction bits and enough integer headroom that no input can cause it to overflow. Choosing the three-term approximation from real-valued coefficients is done outside the block.

Top module: `sopot_fir`

## Requirements
- R1: `y_o` is the two's-complement value of `sum_k C_k * x[n-k]` scaled by `2^(-E_MIN)`. Here `x[n]` is the newest accepted sample, and `C_k = sum_i s_(k,i) * 2^(e_(k,i))`. The exponent of term i of tap k is the signed `EXP_W`-bit field at bit `(3k+i)*EXP_W` of `TERM_EXP`. With the default terms, the scaled coefficients are 52, 100, 268 and 5 (13, 25, 67 and 1.25).
- R2: Bit `3k+i` of `TERM_NEG` selects the sign of term i of tap k: 1 subtracts the term and 0 adds it.
- R3: A negative exponent is applied with no loss of precision. For example, a unit impulse through the 1+0.5-0.25 tap yields exactly 5 in quarter units.
- R4: Each cycle with `valid_i` high yields exactly one cycle with `valid_o` high. That output appears after the third rising clock edge that follows the capture edge, counting the capture edge as the first.
- R5: The delay line advances only on cycles with `valid_i` high. Idle cycles between samples do not change any later output.
- R6: While `rst_ni` is low, `valid_o` and `y_o` are 0 and the delay line is cleared. After reset, the first outputs treat all earlier samples as zero.
- R7: `y_o` holds its last value whenever `valid_o` is low.
- R8: Full-scale positive and negative inputs on every tap produce the exact result without overflow.
- R9: Samples may be accepted on every clock cycle with no gap, and each produces its own correct output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Qualifies `sample_i` this cycle |
| sample_i | input | DATA_W | Signed input sample |
| valid_o | output | 1 | Qualifies `y_o` this cycle |
| y_o | output | ACC_W | Signed filter output with `-E_MIN` fraction bits |

## Verification
A unit impulse reads the four scaled coefficients back in order. The fourth value, 5, shows two defects at once: a subtract taken as an add would give 7, and a truncated fractional term would give 4 or 6. Samples separated by idle gaps are compared against the same samples sent back to back. A delay line that shifted on idle cycles would mix zeros into the sum. A reset in the middle of a stream checks that stale samples are gone, since surviving history would appear in the first outputs after reset. Alternating full-scale values test the accumulator headroom, where a narrow adder would wrap the sign, and the hold checks catch any output that changes while `valid_o` is low.

// File: rtl/sopot_fir_pkg.sv
package sopot_fir_pkg;

  localparam int TERMS = 3;

  // full-precision width: sample + shift span + growth of TERMS*taps terms + sign
  function automatic int acc_width(int data_w, int e_min, int e_max, int taps);
    return data_w + (e_max - e_min) + $clog2(TERMS * taps) + 1;
  endfunction

endpackage

// File: rtl/sopot_delay_line.sv
module sopot_delay_line #(
  parameter int DATA_W = 12,
  parameter int TAPS   = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         shift_i,
  input  logic [DATA_W-1:0]            sample_i,
  output logic [TAPS-1:0][DATA_W-1:0]  taps_o
);

  logic [TAPS-1:0][DATA_W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
    end else if (shift_i) begin
      line_q[0] <= sample_i;
      for (int k = 1; k < TAPS; k++) line_q[k] <= line_q[k-1];
    end
  end

  assign taps_o = line_q;

  p_shift_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> taps_o[0] == $past(sample_i));

  p_shift_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(taps_o));

endmodule

// File: rtl/sopot_tap.sv
module sopot_tap
  import sopot_fir_pkg::*;
#(
  parameter int                      DATA_W = 12,
  parameter int                      ACC_W  = 25,
  parameter int                      EXP_W  = 4,
  parameter int                      E_MIN  = -2,
  parameter logic [TERMS-1:0]        NEG    = '0,
  parameter logic [TERMS*EXP_W-1:0]  EXP    = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [DATA_W-1:0] sample_i,
  output logic signed [ACC_W-1:0]  prod_o
);

  logic signed [ACC_W-1:0] ext_w;
  logic signed [ACC_W-1:0] term_w [TERMS];
  logic signed [ACC_W-1:0] prod_d;

  // sample pre-scaled by 2^-E_MIN, so negative exponents need no right shift
  assign ext_w = ACC_W'(sample_i);

  for (genvar i = 0; i < TERMS; i++) begin : g_term
    localparam logic signed [EXP_W-1:0] EV = EXP[i*EXP_W +: EXP_W];
    localparam int SH = int'(EV) - E_MIN;
    assign term_w[i] = ext_w <<< SH;
  end

  always_comb begin
    prod_d = '0;
    for (int i = 0; i < TERMS; i++) begin
      if (NEG[i]) prod_d = prod_d - term_w[i];
      else        prod_d = prod_d + term_w[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prod_o <= '0;
    else if (en_i) prod_o <= prod_d;
  end

  p_zero_tap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sample_i == '0) |=> prod_o == '0);

  p_prod_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(prod_o));

endmodule

// File: rtl/sopot_sum.sv
module sopot_sum #(
  parameter int ACC_W = 25,
  parameter int TAPS  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic [TAPS-1:0][ACC_W-1:0] prods_i,
  output logic [ACC_W-1:0]           y_o
);

  logic signed [ACC_W-1:0] total_d;

  always_comb begin
    total_d = '0;
    for (int k = 0; k < TAPS; k++) total_d = total_d + $signed(prods_i[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   y_o <= '0;
    else if (en_i) y_o <= total_d;
  end

  p_out_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(y_o));

endmodule

// File: rtl/sopot_fir.sv
module sopot_fir
  import sopot_fir_pkg::*;
#(
  parameter int                         DATA_W   = 12,
  parameter int                         TAPS     = 4,
  parameter int                         EXP_W    = 4,
  parameter int                         E_MIN    = -2,
  parameter int                         E_MAX    = 6,
  // per tap k, term i: field (3k+i); defaults 8+4+1, 16+8+1, 64+2+1, 1+0.5-0.25
  parameter logic [TERMS*TAPS*EXP_W-1:0] TERM_EXP = 48'hEF0016034023,
  parameter logic [TERMS*TAPS-1:0]       TERM_NEG = 12'h800,
  localparam int                        ACC_W    = acc_width(DATA_W, E_MIN, E_MAX, TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              valid_o,
  output logic [ACC_W-1:0]  y_o
);

  logic [TAPS-1:0][DATA_W-1:0] taps_w;
  logic [TAPS-1:0][ACC_W-1:0]  prods_w;
  logic                        line_v_q;
  logic                        prod_v_q;

  sopot_delay_line #(
    .DATA_W (DATA_W),
    .TAPS   (TAPS)
  ) u_line (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  (valid_i),
    .sample_i (sample_i),
    .taps_o   (taps_w)
  );

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic signed [ACC_W-1:0] prod_w;

    sopot_tap #(
      .DATA_W (DATA_W),
      .ACC_W  (ACC_W),
      .EXP_W  (EXP_W),
      .E_MIN  (E_MIN),
      .NEG    (TERM_NEG[TERMS*k +: TERMS]),
      .EXP    (TERM_EXP[TERMS*k*EXP_W +: TERMS*EXP_W])
    ) u_tap (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (line_v_q),
      .sample_i ($signed(taps_w[k])),
      .prod_o   (prod_w)
    );

    assign prods_w[k] = prod_w;
  end

  sopot_sum #(
    .ACC_W (ACC_W),
    .TAPS  (TAPS)
  ) u_sum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (prod_v_q),
    .prods_i (prods_w),
    .y_o     (y_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_v_q <= 1'b0;
      prod_v_q <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      line_v_q <= valid_i;
      prod_v_q <= line_v_q;
      valid_o  <= prod_v_q;
    end
  end

  // cycles since reset, so the latency check never looks before reset
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
  end

  p_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_q == 2'd3 |-> valid_o == $past(valid_i, 3));

  p_y_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(y_o));

endmodule

// File: tb/sopot_fir_test.sv
module sopot_fir_test;

  localparam int DATA_W = 12;
  localparam int ACC_W  = 25;
  localparam int TAPS   = 4;

  logic                     clk = 1'b0;
  logic                     rst_ni = 1'b0;
  logic                     valid_i = 1'b0;
  logic [DATA_W-1:0]        sample_i = '0;
  logic                     valid_o;
  logic signed [ACC_W-1:0]  y_o;

  sopot_fir uut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .sample_i (sample_i),
    .valid_o  (valid_o),
    .y_o      (y_o)
  );

  always #10 clk = ~clk;

  // coefficients in quarter units: 13, 25, 67, 1+0.5-0.25
  int        coef [TAPS] = '{52, 100, 268, 5};
  int        n_chk = 0;
  int        n_bad = 0;
  bit        done = 1'b0;
  string     cur_tag = "R6";

  longint    hist [TAPS];
  bit        vq [2];
  longint    eq [2];
  string     tq [2];
  longint    last_y = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    for (int j = 0; j < 2; j++) begin vq[j] = 1'b0; eq[j] = 0; tq[j] = ""; end
    last_y = 0;
  endtask

  // sampled mid-high, away from both edges
  always @(posedge clk) begin
    #5;
    if (!done) begin
      if (!rst_ni) begin
        chk(valid_o == 1'b0, "R6 valid_o in reset", longint'(valid_o), 0);
        chk(y_o == '0, "R6 y_o in reset", longint'(y_o), 0);
        model_clear();
      end else begin
        longint e;
        chk(valid_o == vq[1], "R4 valid latency", longint'(valid_o), longint'(vq[1]));
        if (vq[1]) begin
          chk(longint'(y_o) == eq[1], tq[1], longint'(y_o), eq[1]);
          last_y = longint'(y_o);
        end else begin
          chk(longint'(y_o) == last_y, "R7 hold", longint'(y_o), last_y);
        end
        e = 0;
        if (valid_i) begin
          for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
          hist[0] = longint'($signed(sample_i));
          for (int k = 0; k < TAPS; k++) e += coef[k] * hist[k];
        end
        vq[1] = vq[0]; eq[1] = eq[0]; tq[1] = tq[0];
        vq[0] = valid_i; eq[0] = e; tq[0] = cur_tag;
      end
    end
  end

  task automatic push(input int x);
    @(negedge clk);
    valid_i  = 1'b1;
    sample_i = DATA_W'(x);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  task automatic t_reset();
    cur_tag = "R6 reset";
    @(negedge clk); rst_ni = 1'b0;
    idle(3);
    @(negedge clk); rst_ni = 1'b1;
    idle(2);
  endtask

  task automatic t_impulse();
    cur_tag = "R1 R3 impulse";
    push(1); idle(6);
    push(-3); idle(6);
  endtask

  task automatic t_sign();
    cur_tag = "R2 step";
    for (int i = 0; i < 6; i++) push(100);
    push(4); idle(6);
  endtask

  task automatic t_gaps();
    cur_tag = "R5 gaps";
    for (int i = 0; i < 8; i++) begin
      push(i * 97 - 300);
      idle(1 + (i % 3));
    end
    idle(4);
  endtask

  task automatic t_stream();
    cur_tag = "R9 back-to-back";
    for (int i = 0; i < 40; i++) push(((i * 613 + 211) % 4096) - 2048);
    idle(5);
  endtask

  task automatic t_extremes();
    cur_tag = "R8 full scale";
    for (int i = 0; i < 5; i++) push(2047);
    for (int i = 0; i < 5; i++) push(-2048);
    for (int i = 0; i < 6; i++) push((i % 2) ? 2047 : -2048);
    idle(5);
  endtask

  task automatic t_mid_reset();
    cur_tag = "R6 history after reset";
    for (int i = 0; i < 4; i++) push(1500 - i * 7);
    @(negedge clk); valid_i = 1'b0; rst_ni = 1'b0;
    idle(2);
    @(negedge clk); rst_ni = 1'b1;
    push(1); idle(6);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    model_clear();
    t_reset();
    t_impulse();
    t_sign();
    t_gaps();
    t_stream();
    t_extremes();
    t_mid_reset();
    idle(2);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule